// File: doc/BRIEF.md
# Banked Host Register Front End for a Network Controller

This block is the host-facing register decoder of a network controller. The host sees a 16-offset I/O window. Offset 0 is present in every bank. Its top two bits choose which bank the other offsets belong to, and in bank 0 its low six bits carry commands. The commands leave the block as one-cycle strobes toward the transmit, receive and reset logic.

Bank 0 holds four byte registers and two word registers. The byte registers are interrupt status, a detection byte, and interrupt mask. The detection byte has a fixed signature and a two-bit counter that steps on every read, so a driver can check that real hardware answers. The two word registers are a pointer into the 32 KiB local buffer RAM and a data port. Each data-port access moves the pointer on by one word, so the host can stream a whole frame through a single offset.

Read data is combinational: it is valid during the cycle in which the host asserts a read. Side effects such as counter steps, pointer advances and register writes take effect at the closing clock edge.

Top module: `nic_host_regs`

## Requirements
- R1: A write to offset 0 in any bank sets the bank to bits 7:6 of the written byte. Reading offset 0 returns the bank in bits 7:6 and zero elsewhere.
- R2: In bank 0, a write to offset 0 is decoded from bits 5:0 as follows. 0x04 produces a pulse on `cmd_pulse[0]` (transmit). 0x08 pulses bit 1 (receive enable). 0x0A pulses bit 2 (receive disable). 0x0B pulses bit 3 (stop receive). 0x0E pulses bit 4 (full reset). 0x1E pulses bit 5 (selective reset). The pulse is high for exactly the cycle after the write. Any other code, or any write made while in banks 1 to 3, pulses nothing.
- R3: In bank 0, offset 2 reads as `{cnt, 6'h24}`, so `(value & 0x2C) == 0x24`. The two-bit `cnt` starts at 0 and goes up by one after every read of that offset, wrapping from 3 to 0.
- R4: The status byte at offset 1 of bank 0 uses bits 3:0: bit 0 receive-stop, bit 1 receive, bit 2 transmit, bit 3 execution. A high `evt_set` bit sets the matching status bit. Writing a 1 to a status bit clears it, so writing 0x0F clears all four. When a set and a clear hit the same bit in the same cycle, the set wins.
- R5: Offset 3 of bank 0 is a read/write mask in bits 3:0, using the same bit layout as status. A set mask bit blocks its status bit. `irq` is high exactly when some status bit is set whose mask bit is clear.
- R6: Offset 0x0C of bank 0 is the 16-bit buffer pointer. A write stores bits 14:1 and forces bit 0 to zero. A read returns the pointer with bits 15 and 0 zero.
- R7: A read of offset 0x0E in bank 0 returns the buffer RAM word at the pointer, then advances the pointer by 2.
- R8: A write of offset 0x0E in bank 0 stores the word at the pointer, then advances the pointer by 2. The pointer wraps from 0x7FFE to 0x0000.
- R9: Offsets not listed above for the current bank read as zero and ignore writes. This includes every offset except 0 in banks 1, 2 and 3.
- R10: A full-reset command sets the bank to 0 and clears status and mask, even against an event in the same cycle. The buffer pointer is left unchanged.
- R11: After reset the bank is 0, status and mask are 0, the counter is 0, the pointer is 0, and `irq` and all command pulses are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_off | input | 4 | Register offset within the window |
| hst_rd | input | 1 | Host read this cycle |
| hst_wr | input | 1 | Host write this cycle |
| hst_wdata | input | 16 | Write data (byte registers use bits 7:0) |
| hst_rdata | output | 16 | Combinational read data |
| evt_set | input | 4 | Status set requests, one bit per status bit |
| cmd_pulse | output | 6 | One-cycle command strobes |
| irq | output | 1 | Unmasked status pending |
| ram_addr | output | 15 | Buffer RAM byte address (bit 0 always zero) |
| ram_we | output | 1 | Buffer RAM write enable |
| ram_wdata | output | 16 | Buffer RAM write data |
| ram_rdata | input | 16 | Buffer RAM read data, combinational on ram_addr |

## Verification
The assertions assume that `hst_rd` and `hst_wr` are never high in the same cycle. They also assume that `ram_rdata` settles within the cycle from `ram_addr`. If either assumption fails, the pointer-advance and command-source properties lose their meaning. The bench drives at most one host access per cycle and provides a RAM that reads combinationally, so both assumptions hold. The bench keeps addresses used in the buffer tests apart in the low 9 address bits, so its small RAM never aliases two live words.

// File: rtl/nic_host_regs_pkg.sv
`timescale 1ns/1ps
package nic_host_regs_pkg;

    localparam int OFF_W   = 4;
    localparam int WORD_W  = 16;
    localparam int EVT_N   = 4;
    localparam int CMD_N   = 6;

    typedef enum logic [1:0] {
        BANK_0 = 2'd0,
        BANK_1 = 2'd1,
        BANK_2 = 2'd2,
        BANK_3 = 2'd3
    } bank_e;

    localparam logic [OFF_W-1:0] OFF_CTRL  = 4'h0;
    localparam logic [OFF_W-1:0] OFF_STAT  = 4'h1;
    localparam logic [OFF_W-1:0] OFF_IDENT = 4'h2;
    localparam logic [OFF_W-1:0] OFF_MASK  = 4'h3;
    localparam logic [OFF_W-1:0] OFF_HPTR  = 4'hC;
    localparam logic [OFF_W-1:0] OFF_DPORT = 4'hE;

    // strobe bit positions
    localparam int CI_XMIT    = 0;
    localparam int CI_RXEN    = 1;
    localparam int CI_RXDIS   = 2;
    localparam int CI_RXSTOP  = 3;
    localparam int CI_FULLRST = 4;
    localparam int CI_SELRST  = 5;

    localparam logic [5:0] IDENT_SIG = 6'h24;

    typedef struct packed {
        logic               rd;
        logic               wr;
        logic [OFF_W-1:0]   off;
        logic [WORD_W-1:0]  wdata;
    } host_acc_t;

    function automatic logic [5:0] cmd_code(input int idx);
        case (idx)
            CI_XMIT:    return 6'h04;
            CI_RXEN:    return 6'h08;
            CI_RXDIS:   return 6'h0A;
            CI_RXSTOP:  return 6'h0B;
            CI_FULLRST: return 6'h0E;
            default:    return 6'h1E;
        endcase
    endfunction

    function automatic logic [7:0] ident_byte(input logic [1:0] cnt);
        return {cnt, IDENT_SIG};
    endfunction

endpackage

// File: rtl/nhr_bank_decode.sv
`timescale 1ns/1ps
module nhr_bank_decode
    import nic_host_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  host_acc_t        acc,
    output bank_e            bank_q,
    output logic [CMD_N-1:0] cmd_q,
    output logic             full_rst_now
);
    logic             wr_ctrl;
    logic             in_b0;
    logic [CMD_N-1:0] hit;

    assign wr_ctrl = acc.wr && (acc.off == OFF_CTRL);
    assign in_b0   = (bank_q == BANK_0);

    for (genvar g = 0; g < CMD_N; g++) begin : g_cmd
        assign hit[g] = wr_ctrl && in_b0 && (acc.wdata[5:0] == cmd_code(g));
    end

    assign full_rst_now = hit[CI_FULLRST];

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= BANK_0;
            cmd_q  <= '0;
        end else begin
            cmd_q <= hit;
            if (full_rst_now)
                bank_q <= BANK_0;
            else if (wr_ctrl)
                bank_q <= bank_e'(acc.wdata[7:6]);
        end
    end
endmodule

// File: rtl/nhr_irq_block.sv
`timescale 1ns/1ps
module nhr_irq_block
    import nic_host_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic             wr_stat,
    input  logic             wr_mask,
    input  logic [EVT_N-1:0] wbits,
    input  logic [EVT_N-1:0] evt,
    output logic [EVT_N-1:0] stat_q,
    output logic [EVT_N-1:0] mask_q,
    output logic             irq
);
    logic [EVT_N-1:0] clr_bits;

    assign clr_bits = wr_stat ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_bits) | evt;
            if (wr_mask)
                mask_q <= wbits;
        end
    end

    assign irq = |(stat_q & ~mask_q);
endmodule

// File: rtl/nhr_buf_port.sv
`timescale 1ns/1ps
module nhr_buf_port
    import nic_host_regs_pkg::*;
#(
    parameter int BUF_AW = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ptr,
    input  logic              dp_rd,
    input  logic              dp_wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [BUF_AW-1:0] ptr,
    output logic              ram_we,
    output logic [WORD_W-1:0] ram_wdata
);
    localparam int WIX_W = BUF_AW - 1;

    logic [WIX_W-1:0] wix_q;

    always_ff @(posedge clk) begin
        if (rst)
            wix_q <= '0;
        else if (wr_ptr)
            wix_q <= wdata[BUF_AW-1:1];
        else if (dp_rd || dp_wr)
            wix_q <= wix_q + 1'b1;
    end

    assign ptr       = {wix_q, 1'b0};
    assign ram_we    = dp_wr;
    assign ram_wdata = wdata;
endmodule

// File: rtl/nic_host_regs.sv
`timescale 1ns/1ps
module nic_host_regs
    import nic_host_regs_pkg::*;
#(
    parameter int BUF_AW = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        hst_off,
    input  logic              hst_rd,
    input  logic              hst_wr,
    input  logic [15:0]       hst_wdata,
    output logic [15:0]       hst_rdata,
    input  logic [3:0]        evt_set,
    output logic [5:0]        cmd_pulse,
    output logic              irq,
    output logic [BUF_AW-1:0] ram_addr,
    output logic              ram_we,
    output logic [15:0]       ram_wdata,
    input  logic [15:0]       ram_rdata
);
    host_acc_t        acc;
    bank_e            bank_q;
    logic             full_rst_now;
    logic             in_b0;
    logic [EVT_N-1:0] stat_q;
    logic [EVT_N-1:0] mask_q;
    logic [1:0]       id_cnt_q;
    logic             id_rd;

    assign acc = '{rd: hst_rd, wr: hst_wr, off: hst_off, wdata: hst_wdata};

    nhr_bank_decode u_bank (
        .clk          (clk),
        .rst          (rst),
        .acc          (acc),
        .bank_q       (bank_q),
        .cmd_q        (cmd_pulse),
        .full_rst_now (full_rst_now)
    );

    assign in_b0 = (bank_q == BANK_0);

    nhr_irq_block u_irq (
        .clk     (clk),
        .rst     (rst),
        .clr_all (full_rst_now),
        .wr_stat (hst_wr && in_b0 && hst_off == OFF_STAT),
        .wr_mask (hst_wr && in_b0 && hst_off == OFF_MASK),
        .wbits   (hst_wdata[EVT_N-1:0]),
        .evt     (evt_set),
        .stat_q  (stat_q),
        .mask_q  (mask_q),
        .irq     (irq)
    );

    nhr_buf_port #(.BUF_AW(BUF_AW)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .wr_ptr    (hst_wr && in_b0 && hst_off == OFF_HPTR),
        .dp_rd     (hst_rd && in_b0 && hst_off == OFF_DPORT),
        .dp_wr     (hst_wr && in_b0 && hst_off == OFF_DPORT),
        .wdata     (hst_wdata),
        .ptr       (ram_addr),
        .ram_we    (ram_we),
        .ram_wdata (ram_wdata)
    );

    // detection counter
    assign id_rd = hst_rd && in_b0 && (hst_off == OFF_IDENT);

    always_ff @(posedge clk) begin
        if (rst)
            id_cnt_q <= '0;
        else if (id_rd)
            id_cnt_q <= id_cnt_q + 2'd1;
    end

    // read multiplexer
    always_comb begin
        hst_rdata = '0;
        if (hst_off == OFF_CTRL) begin
            hst_rdata = {8'h00, bank_q, 6'h00};
        end else if (in_b0) begin
            case (hst_off)
                OFF_STAT:  hst_rdata = {12'h000, stat_q};
                OFF_IDENT: hst_rdata = {8'h00, ident_byte(id_cnt_q)};
                OFF_MASK:  hst_rdata = {12'h000, mask_q};
                OFF_HPTR:  hst_rdata = 16'(ram_addr);
                OFF_DPORT: hst_rdata = ram_rdata;
                default:   hst_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/nhr_chk.sv
`timescale 1ns/1ps
module nhr_chk #(
    parameter int BUF_AW = 15
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        hst_off,
    input logic              hst_rd,
    input logic              hst_wr,
    input logic [15:0]       hst_wdata,
    input logic [15:0]       hst_rdata,
    input logic [3:0]        evt_set,
    input logic [5:0]        cmd_pulse,
    input logic [BUF_AW-1:0] ram_addr,
    input logic [1:0]        bank_q,
    input logic [3:0]        stat_q,
    input logic [3:0]        mask_q
);
    logic b0;
    logic id_rd;
    logic dp_acc;

    assign b0     = (bank_q == 2'd0);
    assign id_rd  = hst_rd && b0 && hst_off == 4'h2;
    assign dp_acc = (hst_rd || hst_wr) && b0 && hst_off == 4'hE;

    // R1
    bank_follow_chk: assert property (@(posedge clk) disable iff (rst)
        hst_wr && hst_off == 4'h0 |=> bank_q == $past(hst_wdata[7:6]));

    // R2
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_pulse));

    // R2
    cmd_source_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_pulse != 6'd0 |-> $past(hst_wr && hst_off == 4'h0 && b0));

    // R3
    ident_sig_chk: assert property (@(posedge clk) disable iff (rst)
        id_rd |-> (hst_rdata & 16'h002C) == 16'h0024);

    // R3
    ident_step_chk: assert property (@(posedge clk) disable iff (rst)
        id_rd && $past(id_rd) && $past(!rst) |->
            hst_rdata[7:6] == 2'($past(hst_rdata[7:6]) + 2'd1));

    // R4
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        hst_wr && b0 && hst_off == 4'h1 && evt_set == 4'd0 |=>
            (stat_q & $past(hst_wdata[3:0])) == 4'd0);

    // R7
    dport_step_chk: assert property (@(posedge clk) disable iff (rst)
        dp_acc |=> ram_addr == BUF_AW'($past(ram_addr) + 2));

    // R9
    undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
        hst_rd && !b0 && hst_off != 4'h0 |-> hst_rdata == 16'h0000);

    // R10
    full_rst_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_pulse[4] |-> bank_q == 2'd0 && stat_q == 4'd0 && mask_q == 4'd0);
endmodule

bind nic_host_regs nhr_chk #(.BUF_AW(BUF_AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hst_off   (hst_off),
    .hst_rd    (hst_rd),
    .hst_wr    (hst_wr),
    .hst_wdata (hst_wdata),
    .hst_rdata (hst_rdata),
    .evt_set   (evt_set),
    .cmd_pulse (cmd_pulse),
    .ram_addr  (ram_addr),
    .bank_q    (bank_q),
    .stat_q    (stat_q),
    .mask_q    (mask_q)
);

// File: tb/nic_host_regs_tb.sv
`timescale 1ns/1ps
module nic_host_regs_tb;
    localparam int BUF_AW = 15;

    logic              clk = 1'b0;
    logic              rst;
    logic [3:0]        hst_off = '0;
    logic              hst_rd = 1'b0;
    logic              hst_wr = 1'b0;
    logic [15:0]       hst_wdata = '0;
    logic [15:0]       hst_rdata;
    logic [3:0]        evt_set = '0;
    logic [5:0]        cmd_pulse;
    logic              irq;
    logic [BUF_AW-1:0] ram_addr;
    logic              ram_we;
    logic [15:0]       ram_wdata;
    logic [15:0]       ram_rdata;

    always #2.5 clk = ~clk;

    nic_host_regs #(.BUF_AW(BUF_AW)) u_dut (
        .clk(clk), .rst(rst), .hst_off(hst_off), .hst_rd(hst_rd), .hst_wr(hst_wr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .evt_set(evt_set),
        .cmd_pulse(cmd_pulse), .irq(irq), .ram_addr(ram_addr), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // small buffer RAM, indexed by address bits 8:1
    logic [15:0] bram [0:255];
    assign ram_rdata = bram[ram_addr[8:1]];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) bram[i] <= 16'h0000;
        end else if (ram_we) begin
            bram[ram_addr[8:1]] <= ram_wdata;
        end
    end

    // reference model
    int          m_bank, m_stat, m_mask, m_cnt, m_wix;
    logic [5:0]  m_pulse;
    logic [15:0] mmem [int];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int model_read(input logic [3:0] off);
        if (off == 4'h0) return m_bank << 6;
        if (m_bank != 0) return 0;
        case (off)
            4'h1: return m_stat;
            4'h2: return (m_cnt << 6) | 'h24;
            4'h3: return m_mask;
            4'hC: return m_wix * 2;
            4'hE: return mmem.exists(m_wix) ? int'(mmem[m_wix]) : 0;
            default: return 0;
        endcase
    endfunction

    task automatic model_step(input logic [3:0] off, input logic rd, input logic wr,
                              input logic [15:0] wd, input logic [3:0] ev);
        logic [5:0] np   = '0;
        bit         full = 0;
        bit         b0   = (m_bank == 0);
        int         clr  = 0;
        if (wr && off == 4'h0) begin
            if (b0) begin
                case (wd[5:0])
                    6'h04: np[0] = 1'b1;
                    6'h08: np[1] = 1'b1;
                    6'h0A: np[2] = 1'b1;
                    6'h0B: np[3] = 1'b1;
                    6'h0E: begin np[4] = 1'b1; full = 1; end
                    6'h1E: np[5] = 1'b1;
                    default: ;
                endcase
            end
            m_bank = full ? 0 : int'(wd[7:6]);
        end
        if (wr && b0 && off == 4'h1) clr = int'(wd[3:0]);
        m_stat = full ? 0 : ((m_stat & ~clr & 'hF) | int'(ev));
        if (full) m_mask = 0;
        else if (wr && b0 && off == 4'h3) m_mask = int'(wd[3:0]);
        if (rd && b0 && off == 4'h2) m_cnt = (m_cnt + 1) % 4;
        if (wr && b0 && off == 4'hC) m_wix = int'(wd[14:1]);
        else if (b0 && off == 4'hE && (rd || wr)) begin
            if (wr) mmem[m_wix] = wd;
            m_wix = (m_wix + 1) % 16384;
        end
        m_pulse = np;
    endtask

    // one bus cycle: drive, compare registered outputs and read data, advance model
    task automatic cyc(input logic [3:0] off, input logic rd, input logic wr,
                       input logic [15:0] wd, input logic [3:0] ev, input string tag);
        int exp;
        @(negedge clk);
        hst_off = off; hst_rd = rd; hst_wr = wr; hst_wdata = wd; evt_set = ev;
        #1;
        chk(cmd_pulse == m_pulse, "R2 cmd_pulse", int'(cmd_pulse), int'(m_pulse));
        chk(irq == ((m_stat & ~m_mask & 'hF) != 0), "R5 irq", int'(irq),
            int'((m_stat & ~m_mask & 'hF) != 0));
        chk(int'(ram_addr) == m_wix * 2, "R7 ram_addr", int'(ram_addr), m_wix * 2);
        if (rd) begin
            exp = model_read(off);
            chk(int'(hst_rdata) == exp, tag, int'(hst_rdata), exp);
        end
        @(posedge clk);
        model_step(off, rd, wr, wd, ev);
    endtask

    task automatic rd_reg(input logic [3:0] off, input string tag);
        cyc(off, 1'b1, 1'b0, 16'h0, 4'h0, tag);
    endtask
    task automatic wr_reg(input logic [3:0] off, input logic [15:0] wd, input string tag);
        cyc(off, 1'b0, 1'b1, wd, 4'h0, tag);
    endtask
    task automatic idle(input logic [3:0] ev);
        cyc(4'h0, 1'b0, 1'b0, 16'h0, ev, "idle");
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        m_bank = 0; m_stat = 0; m_mask = 0; m_cnt = 0; m_wix = 0; m_pulse = '0;
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        rd_reg(4'h0, "R11 bank");
        rd_reg(4'h1, "R11 status");
        rd_reg(4'h3, "R11 mask");
        rd_reg(4'hC, "R11 pointer");
        // R3 detection byte and counter wrap
        for (int i = 0; i < 6; i++) rd_reg(4'h2, "R3 ident");

        // R4 status set, W1C, set wins
        idle(4'b0110);
        rd_reg(4'h1, "R4 status set");
        wr_reg(4'h1, 16'h0002, "R4");
        rd_reg(4'h1, "R4 w1c");
        cyc(4'h1, 1'b0, 1'b1, 16'h0004, 4'b0100, "R4");
        rd_reg(4'h1, "R4 set wins");
        wr_reg(4'h1, 16'h000F, "R4");
        rd_reg(4'h1, "R4 clear all");

        // R5 mask and irq
        wr_reg(4'h3, 16'h000B, "R5");
        idle(4'b0100);
        rd_reg(4'h3, "R5 mask");
        wr_reg(4'h3, 16'h000F, "R5");
        idle(4'h0);
        wr_reg(4'h3, 16'h000B, "R5");
        idle(4'h0);

        // R6 pointer
        wr_reg(4'hC, 16'h0123, "R6");
        rd_reg(4'hC, "R6 pointer");

        // R8 / R7 data port
        wr_reg(4'hC, 16'h0010, "R8");
        wr_reg(4'hE, 16'hA1A1, "R8");
        wr_reg(4'hE, 16'hB2B2, "R8");
        wr_reg(4'hE, 16'hC3C3, "R8");
        rd_reg(4'hC, "R8 pointer advance");
        wr_reg(4'hC, 16'h0010, "R7");
        rd_reg(4'hE, "R7 dport");
        rd_reg(4'hE, "R7 dport");
        rd_reg(4'hE, "R7 dport");
        rd_reg(4'hC, "R7 pointer advance");
        // R8 wrap
        wr_reg(4'hC, 16'h7FFE, "R8");
        wr_reg(4'hE, 16'h5A5A, "R8");
        rd_reg(4'hC, "R8 wrap");
        wr_reg(4'hC, 16'h7FFE, "R8");
        rd_reg(4'hE, "R8 wrap data");
        rd_reg(4'hC, "R8 wrap read");

        // R1 / R9 banks
        idle(4'b0001);
        wr_reg(4'h0, 16'h0040, "R1");
        rd_reg(4'h0, "R1 bank1");
        rd_reg(4'h3, "R9 bank1 mask zero");
        rd_reg(4'h1, "R9 bank1 stat zero");
        wr_reg(4'h3, 16'h0004, "R9");
        wr_reg(4'h1, 16'h000F, "R9");
        wr_reg(4'hE, 16'hDEAD, "R9");
        wr_reg(4'h0, 16'h0044, "R2 no cmd in bank1");
        wr_reg(4'h0, 16'h0080, "R1");
        rd_reg(4'h0, "R1 bank2");
        rd_reg(4'hC, "R9 bank2 pointer zero");
        rd_reg(4'h2, "R9 bank2 ident zero");
        wr_reg(4'h0, 16'h00C0, "R1");
        rd_reg(4'h0, "R1 bank3");
        wr_reg(4'h0, 16'h0000, "R1");
        rd_reg(4'h3, "R9 mask kept");
        rd_reg(4'h1, "R9 status kept");
        rd_reg(4'hC, "R9 pointer kept");
        rd_reg(4'h5, "R9 undefined b0");
        wr_reg(4'h5, 16'h00FF, "R9");

        // R2 commands
        wr_reg(4'h0, 16'h0004, "R2");
        wr_reg(4'h0, 16'h0008, "R2");
        wr_reg(4'h0, 16'h000A, "R2");
        wr_reg(4'h0, 16'h000B, "R2");
        wr_reg(4'h0, 16'h001E, "R2");
        wr_reg(4'h0, 16'h0007, "R2 no cmd");
        wr_reg(4'h0, 16'h0024, "R2 bit5 set no cmd");
        idle(4'h0);

        // R10 full reset
        wr_reg(4'h3, 16'h0003, "R10");
        wr_reg(4'hC, 16'h0040, "R10");
        idle(4'b1001);
        cyc(4'h0, 1'b0, 1'b1, 16'h000E, 4'b0100, "R10");
        rd_reg(4'h0, "R10 bank");
        rd_reg(4'h1, "R10 status");
        rd_reg(4'h3, "R10 mask");
        rd_reg(4'hC, "R10 pointer kept");
        idle(4'h0);

        done = 1;
        summary();
        $finish;
    end
endmodule